// File: doc/BRIEF.md
# Programmable System Clock Prescaler

This block turns the selected oscillator clock into a slower internal system clock. An 8-bit reload value written by software sets the ratio. The mapping is inverted compared with a plain divide-by-N register: the divide ratio is 2 × (256 − R). A value of FFh therefore gives the fastest internal clock (oscillator / 2), and 00h gives the slowest (oscillator / 512). The block drives a divided clock with a 50% duty cycle. It also drives a one-cycle enable pulse once per divided period, for logic that stays on the oscillator clock.

A counter counts up from the reload value. Each time it reaches all ones, the phase state machine swaps phase. The machine has two states:
- `PH_HIGH`: the divided clock is high.
- `PH_LOW`: the divided clock is low.

It has two transitions:
- *half-wrap*: `PH_HIGH` to `PH_LOW`. The counter reloads with the value that is already active.
- *period-wrap*: `PH_LOW` to `PH_HIGH`. The counter reloads with the value software last wrote, and that value becomes active.

A write lands in a shadow register and can be read back at once. It changes the output only at the next period-wrap, so the divided clock never shows a shortened or stretched pulse. A synchronous reset returns to `PH_HIGH` with the reload value set to FFh.

Top module: `sysclk_prescaler`

## Requirements
- R1: After synchronous reset, `rd_data` reads FFh, `clk_div` is high in the first cycle after reset is released, and the output divides by 2.
- R2: When `rst` and `wr_en` are both high on the same edge, reset wins: `rd_data` reads FFh afterwards.
- R3: For an active reload value R, `clk_div` stays high for exactly 256 − R cycles and then low for exactly 256 − R cycles, so the period is 2 × (256 − R) cycles at 50% duty.
- R4: Reload value FFh gives a period of 2 cycles (1 high, 1 low).
- R5: Reload value 00h gives a period of 512 cycles (256 high, 256 low).
- R6: `rd_data` returns the last value written. The new value is visible in the cycle after the write edge, and it holds while `wr_en` is low.
- R7: A write made partway through a period does not change that period. The period completes with the old high and low lengths, and the new value governs the periods that start after it.
- R8: `tick` is high for exactly one cycle per divided period: the last low cycle, immediately before `clk_div` rises. It is never high while `clk_div` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the reload register |
| wr_data | input | 8 | Reload value to write |
| rd_data | output | 8 | Last value written to the reload register |
| clk_div | output | 1 | Divided clock, 50% duty |
| tick | output | 1 | One-cycle enable, one per divided period |

## Verification
If the phase state or the counter goes wrong, the fault shows at the ports as a high or low run on `clk_div` whose length differs from 256 − R. It becomes visible within one divided period, at most 512 oscillator cycles. If the active value is loaded too early, the period in which a write lands is cut short, and measuring that single period exposes it. A misplaced or duplicated `tick` shows up in the same period as the phase error that caused it, because the pulse is counted against the rising edge of `clk_div`.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
    // Phase of the divided clock: value equals the output level.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/clkpre_reload_reg.sv
module clkpre_reload_reg #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] shadow_q
);
    localparam logic [RW-1:0] RESET_VAL = '1;

    always_ff @(posedge clk) begin
        if (rst)        shadow_q <= RESET_VAL;
        else if (wr_en) shadow_q <= wr_data;
    end

    // R6: the stored value only moves on a write
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(shadow_q));

    // R6: a write is captured as given
    assert_capture_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (shadow_q == $past(wr_data)));
endmodule

// File: rtl/clkpre_phase_fsm.sv
module clkpre_phase_fsm
    import clkpre_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] shadow,
    output logic          clk_div,
    output logic          tick
);
    localparam logic [RW-1:0] TOP = '1;

    phase_e        state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] active_q, active_d;
    logic          wrap;

    assign wrap = (cnt_q == TOP);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_HIGH;
            cnt_q    <= TOP;
            active_q <= TOP;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            active_q <= active_d;
        end
    end

    // Next state: half-wrap reuses the active value, period-wrap adopts the shadow
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q + 1'b1;
        active_d = active_q;
        unique case (state_q)
            PH_HIGH: begin
                if (wrap) begin
                    state_d = PH_LOW;
                    cnt_d   = active_q;
                end
            end
            PH_LOW: begin
                if (wrap) begin
                    state_d  = PH_HIGH;
                    cnt_d    = shadow;
                    active_d = shadow;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        clk_div = (state_q == PH_HIGH);
        tick    = (state_q == PH_LOW) && wrap;
    end

    // R3: the phase flips exactly when the counter wraps
    assert_flip_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (clk_div != $past(clk_div)));

    assert_hold_mid_phase_R3: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(clk_div));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7: the governing value changes only at a period boundary
    assert_active_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(active_q));

    // R8: the pulse is followed by a rising divided clock
    assert_tick_before_rise_R8: assert property (@(posedge clk) disable iff (rst)
        tick |=> $rose(clk_div));

    assert_no_tick_high_R8: assert property (@(posedge clk) disable iff (rst)
        clk_div |-> !tick);
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] rd_data,
    output logic          clk_div,
    output logic          tick
);
    logic [RW-1:0] shadow;

    clkpre_reload_reg #(.RW(RW)) u_reload (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .shadow_q (shadow)
    );

    clkpre_phase_fsm #(.RW(RW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .shadow  (shadow),
        .clk_div (clk_div),
        .tick    (tick)
    );

    assign rd_data = shadow;
endmodule

// File: tb/tb_sysclk_prescaler.sv
module tb_sysclk_prescaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       clk_div;
    logic       tick;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int NV = 8;
    localparam logic [7:0] VR [NV] = '{8'hFF, 8'hFE, 8'hFD, 8'hF0, 8'hC3, 8'h80, 8'h01, 8'h00};
    localparam int         VH [NV] = '{1, 2, 3, 16, 61, 128, 255, 256};

    always #4 clk = ~clk;   // 125 MHz

    sysclk_prescaler dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clk_div(clk_div), .tick(tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 readback", int'(rd_data), int'(v));
    endtask

    // Measure one full period starting at a rising clk_div; optionally write at high cycle wr_at.
    task automatic measure(input int wr_at, input logic [7:0] wv,
                           output int h, output int l, output int nt, output int last_t);
        h = 0; l = 0; nt = 0; last_t = 0;
        while (clk_div) @(negedge clk);
        while (!clk_div) @(negedge clk);
        while (clk_div) begin
            h++;
            if (tick) nt++;
            if (h == wr_at) begin wr_en = 1'b1; wr_data = wv; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        while (!clk_div) begin
            l++;
            last_t = int'(tick);
            if (tick) nt++;
            @(negedge clk);
        end
    endtask

    task automatic check_period(input string req, input int exp_half);
        int h, l, nt, lt;
        measure(0, 8'h00, h, l, nt, lt);
        check({req, " high"}, h, exp_half);
        check({req, " low"}, l, exp_half);
        check("R8 ticks per period", nt, 1);
        check("R8 tick in last low cycle", lt, 1);
    endtask

    initial begin
        int h, l, nt, lt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset release
        check("R1 reset readback", int'(rd_data), 255);
        check("R1 clk_div high after reset", int'(clk_div), 1);
        check_period("R1 divide by 2", 1);

        // Vector table: R3, R4 (FFh), R5 (00h), R6
        for (int i = 0; i < NV; i++) begin
            int dh, dl, dn, dt;
            write_reg(VR[i]);
            measure(0, 8'h00, dh, dl, dn, dt);   // may still be the old period
            check_period("R3 ratio", VH[i]);
        end

        // R7: write mid-period; current period keeps the old length
        write_reg(8'hF0);
        check_period("R7 settle", 16);
        measure(4, 8'hFF, h, l, nt, lt);
        check("R7 interrupted high", h, 16);
        check("R7 interrupted low", l, 16);
        check("R7 readback", int'(rd_data), 255);
        check_period("R7 new value", 1);

        // R6: value holds without a write
        repeat (20) @(negedge clk);
        check("R6 hold", int'(rd_data), 255);

        // R2: reset wins over a simultaneous write
        write_reg(8'h80);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_data = 8'h33;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        check("R2 reset over write", int'(rd_data), 255);
        check("R2 clk_div high", int'(clk_div), 1);
        check_period("R2 divide by 2", 1);

        // R5 corner once more from reset default
        write_reg(8'h00);
        measure(0, 8'h00, h, l, nt, lt);
        check_period("R5 divide by 512", 256);

        finish_run();
    end
endmodule